// File: doc/BRIEF.md
# Four-Channel Prescaled PWM with Shadowed Update

This block drives four independent pulse-width-modulated outputs from one clock. Each channel divides the clock twice in a row: a prescaler makes one tick every `pre+1` clocks, and a period counter counts `div+1` of those ticks per period. The output is high for the first `hi` ticks of each period and low for the rest. A channel runs only while its enable bit is set.

Software writes the three fields into shadow registers through a simple write/read port. The running waveform does not change until software sets the update bit. The copy into the active configuration then happens at the next period boundary while the channel runs, or at once while it is stopped. The hardware clears the update bit when the copy is done. The `LAYOUT` parameter picks one of two register maps: a single 32-bit word per channel with narrow fields, or two words per channel with 16-bit fields.

Top module: `pwm_quad`

## Requirements
- R1: A running channel with 0 < hi <= div has a period of (pre+1)*(div+1) clocks, and is high for hi*(pre+1) clocks at the start of that period.
- R2: When the active hi is zero, the output stays low for the whole period.
- R3: When the active hi is greater than or equal to div+1, the output stays high for the whole period.
- R4: With LAYOUT=1, channel n has a field word at byte offset 8n, holding hi in [31:16] and div in [15:0]. It has a control word at offset 8n+4, holding enable in bit 31, update in bit 30 and pre in [15:0]. Bits [29:16] of the control word read as zero.
- R5: With LAYOUT=0, channel n has one word at offset 4n: enable in bit 31, update in bit 30, pre in [29:22], hi in [20:10] and div in [9:0]. Bit 21 is ignored on write and reads as zero.
- R6: Reads return the shadow field values. Once the transfer is done, the update bit reads back as zero.
- R7: Writing new fields to a running channel without setting update leaves its waveform unchanged. Setting update applies the new fields from the next period boundary on.
- R8: While a channel is disabled, its output is low. An update requested while it is disabled is applied within two clocks.
- R9: Clearing enable keeps the stored fields. Setting enable again, with no rewrite, brings back the same waveform.
- R10: After reset, every output is low and every register reads zero.
- R11: With LAYOUT=0, writes to addresses beyond the last channel are ignored, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registers and the counters |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W | Byte address for writes and reads |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| pwmOut | output | NUM_CH | One PWM output per channel |

## Verification
The bench builds two copies of the block, both with four channels and a 5-bit address. One copy uses LAYOUT=1, where 16-bit fields make the full-high case (hi above div) and the field readback easy to reach. The other copy uses LAYOUT=0, so the packed single-word field positions, the ignored bit 21 and the unmapped upper half of the address space can be checked. Waveforms are measured edge to edge on the outputs. This covers period and high time under several prescaler settings, and shows that a pending update waits for a period boundary while the channel runs.

// File: rtl/pwm_quad_pkg.sv
`timescale 1ns/1ps
package pwm_quad_pkg;
  // Widest field over both layouts; narrower layouts zero-extend into it.
  localparam int CFG_W = 16;

  typedef struct packed {
    logic [CFG_W-1:0] pre;
    logic [CFG_W-1:0] hi;
    logic [CFG_W-1:0] div;
  } chCfg_t;

  // Per-channel strobes from control to datapath.
  typedef struct packed {
    logic load;   // copy shadow fields into the active set this cycle
    logic run;    // counters advance and the output may go high
  } chStrobe_t;
endpackage

// File: rtl/pwm_quad_ctrl.sv
`timescale 1ns/1ps
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LAYOUT = 1,
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [31:0]              wrData,
  input  logic [NUM_CH-1:0]        chWrap,
  output logic [31:0]              rdData,
  output chCfg_t [NUM_CH-1:0]      shadowCfg,
  output chStrobe_t [NUM_CH-1:0]   strobe,
  output logic [NUM_CH-1:0]        chEn,
  output logic [NUM_CH-1:0]        chUpd
);
  localparam int CH_BITS    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SEL_SHIFT  = (LAYOUT == 1) ? 3 : 2;
  localparam int SPAN_SHIFT = SEL_SHIFT + CH_BITS;

  logic [CH_BITS-1:0] chSel;
  logic               inRange;
  logic               selCfg;
  logic               selCtl;
  logic [CFG_W-1:0]   wrPre;
  logic [CFG_W-1:0]   wrHi;
  logic [CFG_W-1:0]   wrDiv;
  logic [NUM_CH-1:0]  running;
  chCfg_t             rdCfg;
  logic               rdEnBit;
  logic               rdUpdBit;

  assign chSel   = CH_BITS'(addr >> SEL_SHIFT);
  assign inRange = ((addr >> SPAN_SHIFT) == '0) && (int'(chSel) < NUM_CH);

  // Field placement depends on the layout
  generate
    if (LAYOUT == 1) begin : g_twoWord
      logic unusedAddr;
      assign unusedAddr = ^addr[1:0];
      assign selCfg = !addr[2];
      assign selCtl = addr[2];
      assign wrHi   = wrData[31:16];
      assign wrDiv  = wrData[15:0];
      assign wrPre  = wrData[15:0];
      assign rdData = !inRange ? 32'h0 :
                      addr[2]  ? {rdEnBit, rdUpdBit, 14'h0, rdCfg.pre} :
                                 {rdCfg.hi, rdCfg.div};
    end else begin : g_oneWord
      logic unusedBits;
      assign unusedBits = ^{addr[1:0], wrData[21], rdCfg.pre[15:8],
                            rdCfg.hi[15:11], rdCfg.div[15:10]};
      assign selCfg = 1'b1;
      assign selCtl = 1'b1;
      assign wrPre  = {8'h0, wrData[29:22]};
      assign wrHi   = {5'h0, wrData[20:10]};
      assign wrDiv  = {6'h0, wrData[9:0]};
      assign rdData = !inRange ? 32'h0 :
                      {rdEnBit, rdUpdBit, rdCfg.pre[7:0], 1'b0,
                       rdCfg.hi[10:0], rdCfg.div[9:0]};
    end
  endgenerate

  always_comb begin
    rdCfg    = shadowCfg[chSel];
    rdEnBit  = chEn[chSel];
    rdUpdBit = chUpd[chSel];
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit = wrEn && inRange && (int'(chSel) == i);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          shadowCfg[i] <= '0;
          chEn[i]      <= 1'b0;
          chUpd[i]     <= 1'b0;
          running[i]   <= 1'b0;
        end else begin
          if (hit && selCfg) begin
            shadowCfg[i].hi  <= wrHi;
            shadowCfg[i].div <= wrDiv;
          end
          if (hit && selCtl) begin
            shadowCfg[i].pre <= wrPre;
            chEn[i]          <= wrData[31];
          end
          if (hit && selCtl && wrData[30]) chUpd[i] <= 1'b1;
          else if (strobe[i].load)         chUpd[i] <= 1'b0;
          running[i] <= chEn[i];
        end
      end

      // Transfer at a period boundary, or at once while stopped
      assign strobe[i].load = chUpd[i] && (!running[i] || chWrap[i]);
      assign strobe[i].run  = running[i];
    end
  endgenerate
endmodule

// File: rtl/pwm_quad_dp.sv
`timescale 1ns/1ps
module pwm_quad_dp
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  chStrobe_t [NUM_CH-1:0]  strobe,
  input  chCfg_t [NUM_CH-1:0]     shadowCfg,
  output logic [NUM_CH-1:0]       pwmOut,
  output logic [NUM_CH-1:0]       chWrap,
  output chCfg_t [NUM_CH-1:0]     actCfg
);
  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [CFG_W-1:0] preCnt;
      logic [CFG_W-1:0] perCnt;
      logic             tick;

      assign tick      = (preCnt == actCfg[i].pre);
      assign chWrap[i] = strobe[i].run && tick && (perCnt == actCfg[i].div);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          actCfg[i] <= '0;
          preCnt    <= '0;
          perCnt    <= '0;
        end else begin
          if (strobe[i].load) actCfg[i] <= shadowCfg[i];
          if (!strobe[i].run) begin
            preCnt <= '0;
            perCnt <= '0;
          end else if (tick) begin
            preCnt <= '0;
            perCnt <= (perCnt == actCfg[i].div) ? '0 : perCnt + 1'b1;
          end else begin
            preCnt <= preCnt + 1'b1;
          end
        end
      end

      assign pwmOut[i] = strobe[i].run && (perCnt < actCfg[i].hi);
    end
  endgenerate
endmodule

// File: rtl/pwm_quad.sv
`timescale 1ns/1ps
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LAYOUT = 1,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chCfg_t [NUM_CH-1:0]    shadowCfg;
  chCfg_t [NUM_CH-1:0]    actCfg;
  chStrobe_t [NUM_CH-1:0] strobe;
  logic [NUM_CH-1:0]      chWrap;
  logic [NUM_CH-1:0]      chEn;
  logic [NUM_CH-1:0]      chUpd;

  pwm_quad_ctrl #(.NUM_CH(NUM_CH), .LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .chWrap(chWrap), .rdData(rdData), .shadowCfg(shadowCfg),
    .strobe(strobe), .chEn(chEn), .chUpd(chUpd)
  );

  pwm_quad_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .shadowCfg(shadowCfg),
    .pwmOut(pwmOut), .chWrap(chWrap), .actCfg(actCfg)
  );
endmodule

// File: rtl/pwm_quad_chk.sv
`timescale 1ns/1ps
module pwm_quad_chk
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [NUM_CH-1:0]      pwmOut,
  input logic [NUM_CH-1:0]      chEn,
  input logic [NUM_CH-1:0]      chUpd,
  input logic [NUM_CH-1:0]      chWrap,
  input chStrobe_t [NUM_CH-1:0] strobe,
  input chCfg_t [NUM_CH-1:0]    actCfg
);
  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      AST_RUN_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rstN)
        chEn[i] |=> strobe[i].run);  // R9
      AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
        !strobe[i].run |-> !pwmOut[i]);  // R8
      AST_IDLE_UPD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
        (chUpd[i] && !strobe[i].run && !wrEn) |=> !chUpd[i]);  // R8
      AST_NO_MIDPERIOD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
        (strobe[i].run && !chWrap[i]) |=> $stable(actCfg[i]));  // R7
      AST_ZERO_HI_LOW: assert property (@(posedge clk) disable iff (!rstN)
        (actCfg[i].hi == '0) |-> !pwmOut[i]);  // R2
      AST_FULL_HI_HIGH: assert property (@(posedge clk) disable iff (!rstN)
        (strobe[i].run && (actCfg[i].hi > actCfg[i].div)) |-> pwmOut[i]);  // R3
    end
  endgenerate
endmodule

bind pwm_quad pwm_quad_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .pwmOut(pwmOut), .chEn(chEn),
  .chUpd(chUpd), .chWrap(chWrap), .strobe(strobe), .actCfg(actCfg)
);

// File: tb/test_pwm_quad.sv
`timescale 1ns/1ps
module test_pwm_quad;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrEnS = 1'b0;
  logic [4:0]  addr = '0, addrS = '0;
  logic [31:0] wrData = '0, wrDataS = '0;
  logic [31:0] rdData, rdDataS;
  logic [3:0]  pwm2, pwmS;
  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_quad #(.NUM_CH(4), .LAYOUT(1), .ADDR_W(5)) i_pwm_quad (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pwmOut(pwm2));

  pwm_quad #(.NUM_CH(4), .LAYOUT(0), .ADDR_W(5)) i_pwm_quadSingle (
    .clk(clk), .rstN(rstN), .wrEn(wrEnS), .addr(addrS), .wrData(wrDataS),
    .rdData(rdDataS), .pwmOut(pwmS));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  task automatic wr(input bit single, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    if (single) begin wrEnS = 1; addrS = a; wrDataS = d; end
    else        begin wrEn = 1;  addr = a;  wrData = d;  end
    @(negedge clk);
    wrEn = 0; wrEnS = 0;
  endtask

  task automatic rd(input bit single, input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    if (single) addrS = a; else addr = a;
    #1;
    d = single ? rdDataS : rdData;
  endtask

  function automatic logic lvl(input bit single, input int ch);
    return single ? pwmS[ch] : pwm2[ch];
  endfunction

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Rising edge to rising edge: high samples and full period
  task automatic measure(input bit single, input int ch, output int hiCnt, output int perCnt);
    logic prev;
    int guard;
    hiCnt = 0; perCnt = 0; guard = 0;
    @(negedge clk); prev = lvl(single, ch);
    while (guard < 4000) begin
      @(negedge clk); guard++;
      if (lvl(single, ch) && !prev) break;
      prev = lvl(single, ch);
    end
    if (guard >= 4000) return;
    hiCnt = 1;
    while (guard < 4000) begin
      @(negedge clk); guard++;
      if (lvl(single, ch)) hiCnt++; else break;
    end
    perCnt = hiCnt + 1;
    while (guard < 4000) begin
      @(negedge clk); guard++;
      if (!lvl(single, ch)) perCnt++; else break;
    end
  endtask

  task automatic countHigh(input bit single, input int ch, input int n, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (lvl(single, ch)) highs++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    chk("R10 outputs low", {28'h0, pwm2 | pwmS}, 32'h0);
    rd(0, 5'd0, d);  chk("R10 field word", d, 32'h0);
    rd(0, 5'd4, d);  chk("R10 control word", d, 32'h0);
    rd(1, 5'd12, d); chk("R10 single word", d, 32'h0);
  endtask

  task automatic t_basic();
    int h, p;
    logic [31:0] d;
    wr(0, 5'd8, {16'd3, 16'd9});
    wr(0, 5'd12, 32'hC000_0002);
    measure(0, 1, h, p);
    chk("R1 ch1 high", h, 9);
    chk("R1 ch1 period", p, 30);
    rd(0, 5'd12, d); chk("R6 update cleared", d, 32'h8000_0002);
    rd(0, 5'd8, d);  chk("R4 field word", d, 32'h0003_0009);
    wr(0, 5'd16, {16'd2, 16'd4});
    wr(0, 5'd20, 32'hFFFF_0000 | 32'h0000_0000);
    // bits 29:16 set above must read back zero, pre=0
    rd(0, 5'd20, d); chk("R4 control word unused bits", d & 32'h3FFF_FFFF, 32'h0);
    measure(0, 2, h, p);
    chk("R1 ch2 high", h, 2);
    chk("R1 ch2 period", p, 5);
  endtask

  task automatic t_extremes();
    int h;
    wr(0, 5'd24, {16'd0, 16'd3});
    wr(0, 5'd28, 32'hC000_0001);
    idle(4);
    countHigh(0, 3, 40, h); chk("R2 zero high", h, 0);
    wr(0, 5'd24, {16'd4, 16'd3});
    wr(0, 5'd28, 32'hC000_0001);
    idle(12);
    countHigh(0, 3, 40, h); chk("R3 full high", h, 40);
    wr(0, 5'd24, {16'd9, 16'd3});
    wr(0, 5'd28, 32'hC000_0001);
    idle(12);
    countHigh(0, 3, 40, h); chk("R3 hi above div", h, 40);
  endtask

  task automatic t_shadow();
    int h, p;
    logic [31:0] d;
    wr(0, 5'd8, {16'd6, 16'd9});
    measure(0, 1, h, p);
    chk("R7 unchanged high", h, 9);
    chk("R7 unchanged period", p, 30);
    rd(0, 5'd8, d); chk("R6 shadow readback", d, 32'h0006_0009);
    wr(0, 5'd12, 32'hC000_0002);
    measure(0, 1, h, p);
    chk("R7 new high", h, 18);
    chk("R7 new period", p, 30);
  endtask

  task automatic t_disable();
    int h, p;
    logic [31:0] d;
    wr(0, 5'd12, 32'h0000_0002);
    idle(2);
    countHigh(0, 1, 40, h); chk("R8 disabled low", h, 0);
    rd(0, 5'd8, d); chk("R9 fields kept", d, 32'h0006_0009);
    wr(0, 5'd8, {16'd1, 16'd9});
    wr(0, 5'd12, 32'h4000_0002);
    idle(1);
    rd(0, 5'd12, d); chk("R8 idle update cleared", d, 32'h0000_0002);
    countHigh(0, 1, 20, h); chk("R8 still low", h, 0);
    wr(0, 5'd12, 32'h8000_0002);
    measure(0, 1, h, p);
    chk("R9 re-enable high", h, 3);
    chk("R9 re-enable period", p, 30);
  endtask

  task automatic t_single();
    int h, p;
    logic [31:0] d;
    wr(1, 5'd8, 32'hC060_0805);  // pre=1 hi=2 div=5, bit 21 set
    measure(1, 2, h, p);
    chk("R5 single high", h, 4);
    chk("R5 single period", p, 12);
    rd(1, 5'd8, d); chk("R5 single readback", d, 32'h8040_0805);
    wr(1, 5'd16, 32'hC00F_FFFF);
    rd(1, 5'd16, d); chk("R11 unmapped read", d, 32'h0);
    rd(1, 5'd0, d);  chk("R11 ch0 untouched", d, 32'h0);
    idle(2);
    countHigh(1, 0, 20, h); chk("R11 ch0 low", h, 0);
  endtask

  initial begin
    #(4 * 150000);
    nChecks++; nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    t_reset();
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_extremes();
    t_shadow();
    t_disable();
    t_single();
    finishRun();
  end
endmodule